// File: doc/BRIEF.md
# Multicycle RISC Core

A 32-bit processor core that runs each instruction as a short sequence of one-cycle steps. One memory port serves both instruction fetch and data access, and a single ALU does every addition in the core: operand arithmetic, the PC increment and the branch-target sum. Holding registers sit between the steps and are not visible to software: an instruction register, a memory data register, two operand registers and an ALU result register. A state machine drives every multiplexer select and write enable.

The core executes load word, store word, the register-register operations add, sub, and, or and set-less-than, branch-if-equal and an absolute jump. It takes 3 cycles for branches and jumps, 4 for register operations and stores, and 5 for loads. The memory is external and has a combinational read and a clocked write. The core reads the memory in the cycle it raises the read strobe, and writes it at the clock edge that closes a cycle with the write strobe raised.

Top module: `mc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and puts the controller in the fetch step, so the first cycle after reset reads memory at byte address 0.
- R2: In the fetch step the core reads memory at the PC, loads the instruction register, and writes PC+4 into the PC through the shared ALU. The instruction register does not change in any other step.
- R3: Counted from one fetch to the next, branch-if-equal (opcode 0x04) and jump (opcode 0x02) take 3 cycles, register operations (opcode 0x00) and store word take 4, and load word takes 5.
- R4: A register operation writes the result selected by bits [5:0] into the register in bits [15:11]. The codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or and 0x2A signed set-less-than. The sources are the registers in bits [25:21] and [20:16].
- R5: Load word (opcode 0x23) reads memory at the register in bits [25:21] plus the sign-extended bits [15:0]. The address comes from the ALU result register. The word read goes into the register in bits [20:16].
- R6: Store word (opcode 0x2B) writes the register in bits [20:16] to memory at base plus the sign-extended offset. A memory write happens in no other step.
- R7: Branch-if-equal compares the registers in bits [25:21] and [20:16]. If they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2, and this target is computed in the decode step. If they differ, execution continues at PC+4. Negative offsets work.
- R8: Jump loads the PC with the upper 4 bits of PC+4, followed by bits [25:0] of the instruction, followed by two zero bits.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: At most one memory access takes place per cycle. The read and write strobes are never high together.
- R11: An instruction with an opcode outside the supported set goes back to fetch after the decode step (2 cycles in total). It changes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | XLEN | Byte address for the shared memory |
| mem_rd_en | output | 1 | Memory read strobe for fetch or load |
| mem_wr_en | output | 1 | Memory write strobe for store |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Combinational read data from memory |

## Verification
Two things share one cycle in this core. During fetch, the single ALU adds 4 to the PC while memory delivers the instruction. During decode, the same ALU forms a branch target while the register file reads both operands, whatever the instruction turns out to be. The program provokes both overlaps with a taken forward branch, a not-taken branch, a backward self-branch, a jump, and loads and register operations whose speculative target is thrown away. The scoreboard judges each overlap from the ports: every fetch address must match the expected instruction stream, and the gap between fetches must equal the cycle count for the instruction class. Stores that a wrong target would reach are filled with poison beforehand and are checked to be unchanged at the end.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [1:0] OPB_REG  = 2'd0;
  localparam logic [1:0] OPB_FOUR = 2'd1;
  localparam logic [1:0] OPB_IMM  = 2'd2;
  localparam logic [1:0] OPB_IMM4 = 2'd3;

  localparam logic [1:0] PCS_ALU  = 2'd0;
  localparam logic [1:0] PCS_HELD = 2'd1;
  localparam logic [1:0] PCS_JMP  = 2'd2;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MEMADR, S_MEMRD, S_MEMWB,
    S_MEMWR, S_EXEC, S_RWB, S_BRANCH, S_JUMP
  } step_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_FN  = 2'd2
  } alu_mode_e;

  typedef struct packed {
    logic      pc_we;
    logic      pc_we_cond;
    logic      addr_alu;
    logic      mem_rd;
    logic      mem_wr;
    logic      wb_mem;
    logic      ir_we;
    logic [1:0] pc_src;
    alu_mode_e alu_mode;
    logic      opa_reg;
    logic [1:0] opb_sel;
    logic      rf_we;
    logic      dst_rd;
  } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_mode_e    mode,
  input  logic [5:0]   funct,
  output logic [W-1:0] y,
  output logic         zero
);

  logic lt;
  assign lt = $signed(a) < $signed(b);

  always_comb begin
    unique case (mode)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_FN: begin
        unique case (funct)
          FN_SUB:  y = a - b;
          FN_AND:  y = a & b;
          FN_OR:   y = a | b;
          FN_SLT:  y = {{(W-1){1'b0}}, lt};
          default: y = a + b;
        endcase
      end
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5,
  parameter int RD_PORTS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [RD_PORTS-1:0][AW-1:0]  ra,
  output logic [RD_PORTS-1:0][W-1:0]   rd_q,
  input  logic                         we,
  input  logic [AW-1:0]                wa,
  input  logic [W-1:0]                 wd
);

  localparam int NREG = 1 << AW;

  logic [W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) mem[wa] <= wd;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)               q <= '0;
      else if (ra[p] == '0)  q <= '0;
      else                   q <= mem[ra[p]];
    end
    assign rd_q[p] = q;
  end

  // R9
  r0_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ra[0]) == '0) |-> (rd_q[0] == '0));

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output ctrl_t      c,
  output step_e      st
);

  step_e st_q, st_nxt;
  logic [2:0] step_cnt;

  always_comb begin
    unique case (st_q)
      S_FETCH:  st_nxt = S_DECODE;
      S_DECODE: begin
        unique case (opcode)
          OP_LOAD, OP_STORE: st_nxt = S_MEMADR;
          OP_RTYPE:          st_nxt = S_EXEC;
          OP_BEQ:            st_nxt = S_BRANCH;
          OP_JUMP:           st_nxt = S_JUMP;
          default:           st_nxt = S_FETCH;
        endcase
      end
      S_MEMADR: st_nxt = (opcode == OP_LOAD) ? S_MEMRD : S_MEMWR;
      S_MEMRD:  st_nxt = S_MEMWB;
      S_EXEC:   st_nxt = S_RWB;
      default:  st_nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_FETCH;
      step_cnt <= '0;
    end else begin
      st_q     <= st_nxt;
      step_cnt <= (st_nxt == S_FETCH) ? 3'd0 : step_cnt + 3'd1;
    end
  end

  always_comb begin
    c = '0;
    c.alu_mode = ALU_ADD;
    unique case (st_q)
      S_FETCH: begin
        c.mem_rd  = 1'b1;
        c.ir_we   = 1'b1;
        c.opb_sel = OPB_FOUR;
        c.pc_src  = PCS_ALU;
        c.pc_we   = 1'b1;
      end
      S_DECODE: c.opb_sel = OPB_IMM4;
      S_MEMADR: begin
        c.opa_reg = 1'b1;
        c.opb_sel = OPB_IMM;
      end
      S_MEMRD: begin
        c.mem_rd   = 1'b1;
        c.addr_alu = 1'b1;
      end
      S_MEMWB: begin
        c.rf_we  = 1'b1;
        c.wb_mem = 1'b1;
      end
      S_MEMWR: begin
        c.mem_wr   = 1'b1;
        c.addr_alu = 1'b1;
      end
      S_EXEC: begin
        c.opa_reg  = 1'b1;
        c.opb_sel  = OPB_REG;
        c.alu_mode = ALU_FN;
      end
      S_RWB: begin
        c.rf_we  = 1'b1;
        c.dst_rd = 1'b1;
      end
      S_BRANCH: begin
        c.opa_reg    = 1'b1;
        c.opb_sel    = OPB_REG;
        c.alu_mode   = ALU_SUB;
        c.pc_we_cond = 1'b1;
        c.pc_src     = PCS_HELD;
      end
      S_JUMP: begin
        c.pc_we  = 1'b1;
        c.pc_src = PCS_JMP;
      end
      default: ;
    endcase
  end

  assign st = st_q;

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    step_cnt <= 3'd4);
  // R3
  short_class_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_BRANCH || st_q == S_JUMP) |-> (step_cnt == 3'd2));
  // R3
  load_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_MEMWB) |-> (step_cnt == 3'd4));
  // R5
  load_order_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_MEMWB) |-> ($past(st_q) == S_MEMRD));
  // R6
  store_order_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_MEMWR) |-> ($past(st_q) == S_MEMADR));

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RF_AW = 5
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata
);

  localparam int IMM_W   = 16;
  localparam int SX_W    = XLEN - IMM_W;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int OP_LSB  = 26;
  localparam int TGT_W   = 26;
  localparam int PCHI_W  = XLEN - TGT_W - 2;

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, aluout_q, a_q, b_q;
  logic [XLEN-1:0] opa, opb, alu_y, pc_nxt, imm_sx, wb_data;
  logic            alu_zero, pc_en;
  logic [RF_AW-1:0] wa;
  logic [1:0][RF_AW-1:0] ra;
  logic [1:0][XLEN-1:0]  rd_q;
  ctrl_t c;
  step_e st;

  mc_ctrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[OP_LSB +: 6]),
    .c      (c),
    .st     (st)
  );

  assign ra[0] = ir_q[RS_LSB +: RF_AW];
  assign ra[1] = ir_q[RT_LSB +: RF_AW];
  assign wa    = c.dst_rd ? ir_q[RD_LSB +: RF_AW] : ir_q[RT_LSB +: RF_AW];
  assign wb_data = c.wb_mem ? mdr_q : aluout_q;

  mc_regfile #(.W(XLEN), .AW(RF_AW), .RD_PORTS(2)) i_rf (
    .clk  (clk),
    .rst  (rst),
    .ra   (ra),
    .rd_q (rd_q),
    .we   (c.rf_we),
    .wa   (wa),
    .wd   (wb_data)
  );

  assign a_q = rd_q[0];
  assign b_q = rd_q[1];

  assign imm_sx = {{SX_W{ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign opa    = c.opa_reg ? a_q : pc_q;

  always_comb begin
    unique case (c.opb_sel)
      OPB_REG:  opb = b_q;
      OPB_FOUR: opb = XLEN'(4);
      OPB_IMM:  opb = imm_sx;
      default:  opb = imm_sx << 2;
    endcase
  end

  mc_alu #(.W(XLEN)) i_alu (
    .a     (opa),
    .b     (opb),
    .mode  (c.alu_mode),
    .funct (ir_q[5:0]),
    .y     (alu_y),
    .zero  (alu_zero)
  );

  always_comb begin
    unique case (c.pc_src)
      PCS_HELD: pc_nxt = aluout_q;
      PCS_JMP:  pc_nxt = {pc_q[XLEN-1 -: PCHI_W], ir_q[TGT_W-1:0], 2'b00};
      default:  pc_nxt = alu_y;
    endcase
  end

  assign pc_en = c.pc_we | (c.pc_we_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_en)   pc_q <= pc_nxt;
      if (c.ir_we) ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      aluout_q <= alu_y;
    end
  end

  assign mem_addr  = c.addr_alu ? aluout_q : pc_q;
  assign mem_rd_en = c.mem_rd;
  assign mem_wr_en = c.mem_wr;
  assign mem_wdata = b_q;

  // R1
  reset_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_rd_en && mem_addr == '0));
  // R2
  fetch_pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (pc_q == $past(pc_q) + XLEN'(4)));
  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_FETCH) |=> $stable(ir_q));
  // R7
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_BRANCH && a_q == b_q) |=> (pc_q == $past(aluout_q)));
  // R7
  branch_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_BRANCH && a_q != b_q) |=> $stable(pc_q));
  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_JUMP) |=> (pc_q == {$past(pc_q[XLEN-1 -: PCHI_W]), $past(ir_q[TGT_W-1:0]), 2'b00}));
  // R10
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

endmodule

// File: tb/test_mc_core.sv
module test_mc_core;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;
  localparam int IW         = $clog2(MEM_WORDS);
  localparam logic [31:0] DATA_BASE = 32'h100;
  localparam logic [31:0] POISON    = 32'hA5A5_A5A5;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd_en, mem_wr_en;

  logic [31:0] mem [MEM_WORDS];

  mc_core i_mc_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[IW+1:2]];
  always @(posedge clk) if (mem_wr_en) mem[mem_addr[IW+1:2]] <= mem_wdata;

  typedef struct { logic [31:0] addr; int cycles; string req; } fetch_t;
  typedef struct { logic [31:0] addr; logic [31:0] data; string req; } wr_t;
  fetch_t fq[$];
  wr_t    wq[$];

  int checks = 0, errors = 0;
  int cyc = 0, prev_cyc = 0;
  bit have_prev = 0, done = 0;
  fetch_t prev;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic put(logic [31:0] a, logic [31:0] w);
    mem[a[IW+1:2]] = w;
  endtask
  task automatic push_fetch(logic [31:0] a, int cy, string req);
    fetch_t f; f.addr = a; f.cycles = cy; f.req = req; fq.push_back(f);
  endtask
  task automatic push_wr(logic [31:0] a, logic [31:0] d, string req);
    wr_t w; w.addr = a; w.data = d; w.req = req; wq.push_back(w);
  endtask

  // Driver: loads the program and queues every expected fetch and store.
  task automatic drive_program();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    put(32'h100, 32'd7);
    put(32'h104, 32'hFFFF_FFFB);
    put(32'h120, 32'hDEAD_BEEF);
    put(32'h128, 32'h0000_0200);
    put(32'h1E0, POISON); put(32'h1E4, POISON);
    put(32'h1F0, POISON); put(32'h1F4, POISON); put(32'h1F8, POISON);

    put(32'h00, enc_i(6'h23, 0, 1, 16'h0100));     push_fetch(32'h00, 5, "R1 R5 lw");
    put(32'h04, enc_i(6'h23, 0, 2, 16'h0104));     push_fetch(32'h04, 5, "R5 lw");
    put(32'h08, enc_r(1, 2, 3, 6'h20));            push_fetch(32'h08, 4, "R4 add");
    put(32'h0C, enc_r(1, 2, 4, 6'h22));            push_fetch(32'h0C, 4, "R4 sub");
    put(32'h10, enc_r(1, 2, 5, 6'h24));            push_fetch(32'h10, 4, "R4 and");
    put(32'h14, enc_r(1, 2, 6, 6'h25));            push_fetch(32'h14, 4, "R4 or");
    put(32'h18, enc_r(2, 1, 7, 6'h2A));            push_fetch(32'h18, 4, "R4 slt");
    put(32'h1C, enc_r(1, 2, 8, 6'h2A));            push_fetch(32'h1C, 4, "R4 slt");
    put(32'h20, enc_r(1, 1, 0, 6'h20));            push_fetch(32'h20, 4, "R9 add r0");
    put(32'h24, enc_i(6'h04, 1, 2, 16'd5));        push_fetch(32'h24, 3, "R7 beq fall");
    put(32'h28, enc_i(6'h04, 3, 3, 16'd2));        push_fetch(32'h28, 3, "R7 beq taken");
    put(32'h2C, enc_i(6'h2B, 0, 1, 16'h01F0));
    put(32'h30, enc_i(6'h2B, 0, 1, 16'h01F4));
    put(32'h34, 32'hFC00_0000);                    push_fetch(32'h34, 2, "R11 bad op");
    put(32'h38, enc_j(26'h11));                    push_fetch(32'h38, 3, "R8 jump");
    put(32'h3C, enc_i(6'h2B, 0, 1, 16'h01E0));
    put(32'h40, enc_i(6'h2B, 0, 1, 16'h01E4));
    put(32'h44, enc_i(6'h2B, 0, 3, 16'h0108));     push_fetch(32'h44, 4, "R6 sw");
    put(32'h48, enc_i(6'h2B, 0, 4, 16'h010C));     push_fetch(32'h48, 4, "R6 sw");
    put(32'h4C, enc_i(6'h2B, 0, 5, 16'h0110));     push_fetch(32'h4C, 4, "R6 sw");
    put(32'h50, enc_i(6'h2B, 0, 6, 16'h0114));     push_fetch(32'h50, 4, "R6 sw");
    put(32'h54, enc_i(6'h2B, 0, 7, 16'h0118));     push_fetch(32'h54, 4, "R6 sw");
    put(32'h58, enc_i(6'h2B, 0, 8, 16'h011C));     push_fetch(32'h58, 4, "R6 sw");
    put(32'h5C, enc_i(6'h2B, 0, 0, 16'h0120));     push_fetch(32'h5C, 4, "R9 sw r0");
    put(32'h60, enc_i(6'h23, 0, 9, 16'h010C));     push_fetch(32'h60, 5, "R5 lw");
    put(32'h64, enc_i(6'h2B, 0, 9, 16'h0124));     push_fetch(32'h64, 4, "R6 sw");
    put(32'h68, enc_i(6'h23, 0, 11, 16'h0128));    push_fetch(32'h68, 5, "R5 lw");
    put(32'h6C, enc_i(6'h2B, 11, 1, 16'hFFF8));    push_fetch(32'h6C, 4, "R6 sw neg");
    put(32'h70, enc_i(6'h04, 0, 0, 16'hFFFF));     push_fetch(32'h70, 3, "R7 beq back");
    push_fetch(32'h70, 3, "R7 beq back");

    push_wr(32'h108, 32'd2,          "R4 add");
    push_wr(32'h10C, 32'd12,         "R4 sub");
    push_wr(32'h110, 32'd3,          "R4 and");
    push_wr(32'h114, 32'hFFFF_FFFF,  "R4 or");
    push_wr(32'h118, 32'd1,          "R4 slt");
    push_wr(32'h11C, 32'd0,          "R4 slt");
    push_wr(32'h120, 32'd0,          "R9");
    push_wr(32'h124, 32'd12,         "R5");
    push_wr(32'h1F8, 32'd7,          "R6");
  endtask

  // Monitor: pops expectations as fetches and stores appear at the ports.
  always @(negedge clk) begin
    if (!rst && !done) begin
      cyc++;
      if (mem_wr_en) begin
        check(!mem_rd_en, "R10 single access", {31'd0, mem_rd_en}, 32'd0);
        if (wq.size() == 0) begin
          check(1'b0, "R6 unexpected store", mem_addr, 32'hFFFF_FFFF);
        end else begin
          wr_t w;
          w = wq.pop_front();
          check(mem_addr == w.addr, {w.req, " store addr"}, mem_addr, w.addr);
          check(mem_wdata == w.data, {w.req, " store data"}, mem_wdata, w.data);
        end
      end
      if (mem_rd_en && mem_addr < DATA_BASE) begin
        if (have_prev)
          check((cyc - prev_cyc) == prev.cycles, {"R3 cycles ", prev.req},
                32'(cyc - prev_cyc), 32'(prev.cycles));
        if (fq.size() == 0) begin
          done = 1;
        end else begin
          prev = fq.pop_front();
          check(mem_addr == prev.addr, {"R2 fetch ", prev.req}, mem_addr, prev.addr);
          prev_cyc = cyc;
          have_prev = 1;
          if (fq.size() == 0) done = 1;
        end
      end
    end
  end

  initial begin
    drive_program();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_wr_en == 1'b0, "R1 reset no write", {31'd0, mem_wr_en}, 32'd0);
    check(mem_addr == 32'd0 && mem_rd_en, "R1 reset addr", mem_addr, 32'd0);
    @(posedge clk);
    #1 rst = 1'b0;
    while (!done && cyc < WATCHDOG) @(negedge clk);
    if (!done) check(1'b0, "watchdog", 32'(cyc), 32'(WATCHDOG));
    repeat (2) @(negedge clk);
    check(wq.size() == 0, "R6 stores left", 32'(wq.size()), 32'd0);
    check(mem[32'h1F0 >> 2] == POISON, "R7 skipped store", mem[32'h1F0 >> 2], POISON);
    check(mem[32'h1F4 >> 2] == POISON, "R7 skipped store", mem[32'h1F4 >> 2], POISON);
    check(mem[32'h1E0 >> 2] == POISON, "R8 skipped store", mem[32'h1E0 >> 2], POISON);
    check(mem[32'h1E4 >> 2] == POISON, "R8 skipped store", mem[32'h1E4 >> 2], POISON);
    check(mem[32'h120 >> 2] == 32'd0, "R9 r0 stored", mem[32'h120 >> 2], 32'd0);
    check(mem[32'h124 >> 2] == 32'd12, "R5 load back", mem[32'h124 >> 2], 32'd12);
    check(mem[32'h1F8 >> 2] == 32'd7, "R6 negative offset", mem[32'h1F8 >> 2], 32'd7);
    check(mem[32'h128 >> 2] == 32'h200, "R11 data intact", mem[32'h128 >> 2], 32'h200);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule